// File: doc/BRIEF.md
# System-Operation Flag Latch Decoder

This block decodes the system-operation instruction group (main opcode 0) and holds the small set of machine control bits that the group drives. The 4-bit sub-opcode is split into a data bit (bit 3) and a 3-bit flag index (bits 2:0), so each of the eight flags has one set code and one clear code. Flags 0 to 3 are persistent control bits. Examples are interrupt enable and access to the user-mode registers. Flags 4 to 7 are event bits, such as trap and leave-interrupt-context. Setting an event bit produces a single pulse that has already fallen before the instruction ends.

All updates happen at one middle phase of the instruction, selected by a parameter. An event pulse is high for exactly the phase after that. Clearing an event bit does nothing. One exception applies: the clear code of flag 4 (sub-opcode 4'b0100) is reused as a status read. It puts an 8-bit machine status word on the register write-back path for one phase. The word is laid out as follows: bits 3:0 hold the persistent flags and bits 7:4 hold the interrupt-source inputs.

Top module: `sysop_ctl`

## Requirements
- R1: A set code (sub-opcode bit 3 = 1, index 0..3) executed at the update phase drives ctl_o[index] to 1 from the following cycle. The bit then holds until it is explicitly cleared.
- R2: A clear code (sub-opcode bit 3 = 0, index 0..3) executed at the update phase drives ctl_o[index] to 0 from the following cycle.
- R3: When sysop_i is low, or phase_i differs from the update phase, ctl_o, event_o and wb_en_o do not change in response to the sub-opcode.
- R4: A set code with index 4..7 at the update phase raises event_o[index-4] for exactly one cycle, starting the cycle after the update edge.
- R5: Clear codes with index 5, 6 or 7 leave ctl_o, event_o and wb_en_o unchanged.
- R6: Sub-opcode 4'b0100 at the update phase asserts wb_en_o for exactly one cycle. During that cycle wb_data_o = {irq_src_i, ctl_o} as sampled at the update edge, and every bit above 7 reads 0.
- R7: While rst_ni is low, and after reset, ctl_o, event_o and wb_en_o are all 0. Interrupts are therefore disabled.
- R8: At most one event bit is high at a time, and event_o is 0 in the last phase of every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock, one edge per instruction phase |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sysop_i | input | 1 | Decode strobe: current instruction has main opcode 0 |
| sub_op_i | input | 4 | Sub-opcode: bit 3 data, bits 2:0 flag index |
| phase_i | input | 2 | Current phase number within the instruction |
| irq_src_i | input | 4 | Interrupt-source bits from the interrupt controller |
| ctl_o | output | 4 | Persistent control flags |
| event_o | output | 4 | One-phase event pulses |
| wb_en_o | output | 1 | Write-back strobe for the status word |
| wb_data_o | output | 8 | Machine status word for register write-back |

## Verification
The hardest case to reach is a collision between the reused clear code and the event logic. This means a status read that follows directly after an event set, or an event set that follows the previous one within a single instruction of phases. It also includes the no-effect clear codes arriving while persistent flags hold a mixed pattern. Random instruction streams drive the sub-opcode, the decode strobe and the interrupt sources at every phase. This includes phases other than the update phase. Directed sequences then run back-to-back event sets, a status read right after a pulse, and every clear code of the event bits against a known flag state.

// File: rtl/sysop_pkg.sv
package sysop_pkg;
  localparam int unsigned SUB_W      = 4;
  localparam int unsigned IDX_W      = SUB_W - 1;
  localparam int unsigned NUM_FLAGS  = 1 << IDX_W;
  localparam int unsigned NUM_PERSIST = NUM_FLAGS / 2;
  localparam int unsigned NUM_EVENT  = NUM_FLAGS - NUM_PERSIST;
  localparam int unsigned SRC_W      = 4;
  localparam int unsigned STAT_W     = 8;
  // status read reuses the clear code of the first event bit
  localparam logic [SUB_W-1:0] RD_STAT_CODE = {1'b0, IDX_W'(NUM_PERSIST)};

  typedef logic [NUM_FLAGS-1:0]   flag_mask_t;
  typedef logic [NUM_PERSIST-1:0] ctl_t;
  typedef logic [NUM_EVENT-1:0]   evt_t;
endpackage

// File: rtl/sysop_decode.sv
module sysop_decode
  import sysop_pkg::*;
#(
  parameter int unsigned PHASE_W   = 2,
  parameter int unsigned UPD_PHASE = 1
) (
  input  logic               sysop_i,
  input  logic [SUB_W-1:0]   sub_op_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               fire_o,
  output flag_mask_t         set_mask_o,
  output flag_mask_t         clr_mask_o,
  output logic               rd_stat_o
);
  logic             data_bit;
  logic [IDX_W-1:0] idx;

  assign data_bit = sub_op_i[SUB_W-1];
  assign idx      = sub_op_i[IDX_W-1:0];
  assign fire_o   = sysop_i && (phase_i == PHASE_W'(UPD_PHASE));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_mask
    assign set_mask_o[g] = fire_o &&  data_bit && (idx == IDX_W'(g));
    assign clr_mask_o[g] = fire_o && !data_bit && (idx == IDX_W'(g));
  end

  assign rd_stat_o = fire_o && (sub_op_i == RD_STAT_CODE);

  always_comb begin
    assert ($countones({set_mask_o, clr_mask_o}) <= 1)
      else $error("assert_single_target_R1: more than one flag addressed");
  end
endmodule

// File: rtl/sysop_flag_latch.sv
module sysop_flag_latch
  import sysop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  flag_mask_t set_mask_i,
  input  flag_mask_t clr_mask_i,
  output ctl_t       ctl_o,
  output evt_t       event_o
);
  ctl_t ctl_q;
  evt_t evt_q;

  for (genvar g = 0; g < NUM_PERSIST; g++) begin : g_persist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               ctl_q[g] <= 1'b0;
      else if (set_mask_i[g])    ctl_q[g] <= 1'b1;
      else if (clr_mask_i[g])    ctl_q[g] <= 1'b0;
    end
  end

  // event bits self-clear: high only for the phase after the update edge
  for (genvar g = 0; g < NUM_EVENT; g++) begin : g_event
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q[g] <= 1'b0;
      else         evt_q[g] <= set_mask_i[NUM_PERSIST+g] && !evt_q[g];
    end
  end

  assign ctl_o   = ctl_q;
  assign event_o = evt_q;

  assert_ctl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(ctl_q));
  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q != '0) |=> (evt_q == '0));
  assert_pulse_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> (evt_q == '0));
  assert_event_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_q));
endmodule

// File: rtl/sysop_status.sv
module sysop_status
  import sysop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_stat_i,
  input  ctl_t              ctl_i,
  input  logic [SRC_W-1:0]  irq_src_i,
  output logic              wb_en_o,
  output logic [STAT_W-1:0] wb_data_o
);
  localparam int unsigned USED_W = SRC_W + NUM_PERSIST;

  logic [STAT_W-1:0] word_d;
  logic [STAT_W-1:0] word_q;
  logic              en_q;

  always_comb begin
    word_d = '0;
    word_d[USED_W-1:0] = {irq_src_i, ctl_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      word_q <= '0;
    end else begin
      en_q <= rd_stat_i;
      if (rd_stat_i) word_q <= word_d;
    end
  end

  assign wb_en_o   = en_q;
  assign wb_data_o = word_q;

  assert_wb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> !en_q);
  assert_wb_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> $past(rd_stat_i));
endmodule

// File: rtl/sysop_ctl.sv
module sysop_ctl
  import sysop_pkg::*;
#(
  parameter int unsigned PHASE_W   = 2,
  parameter int unsigned UPD_PHASE = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sysop_i,
  input  logic [SUB_W-1:0]     sub_op_i,
  input  logic [PHASE_W-1:0]   phase_i,
  input  logic [SRC_W-1:0]     irq_src_i,
  output logic [NUM_PERSIST-1:0] ctl_o,
  output logic [NUM_EVENT-1:0] event_o,
  output logic                 wb_en_o,
  output logic [STAT_W-1:0]    wb_data_o
);
  localparam int unsigned LAST_PHASE = (1 << PHASE_W) - 1;

  logic       fire;
  logic       rd_stat;
  flag_mask_t set_mask;
  flag_mask_t clr_mask;
  ctl_t       ctl;
  evt_t       evt;

  sysop_decode #(.PHASE_W(PHASE_W), .UPD_PHASE(UPD_PHASE)) u_decode (
    .sysop_i    (sysop_i),
    .sub_op_i   (sub_op_i),
    .phase_i    (phase_i),
    .fire_o     (fire),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .rd_stat_o  (rd_stat)
  );

  sysop_flag_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .ctl_o      (ctl),
    .event_o    (evt)
  );

  sysop_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_stat_i (rd_stat),
    .ctl_i     (ctl),
    .irq_src_i (irq_src_i),
    .wb_en_o   (wb_en_o),
    .wb_data_o (wb_data_o)
  );

  assign ctl_o   = ctl;
  assign event_o = evt;

  assert_reset_quiet_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (ctl_o == '0 && event_o == '0 && !wb_en_o));
  assert_last_phase_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PHASE_W'(LAST_PHASE)) && (UPD_PHASE + 1 < LAST_PHASE + 1)
      |-> (event_o == '0) || (UPD_PHASE + 1 == LAST_PHASE));
endmodule

// File: tb/sysop_ctl_test.sv
module sysop_ctl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sysop_i = 1'b0;
  logic [3:0] sub_op_i = '0;
  logic [1:0] phase_i = '0;
  logic [3:0] irq_src_i = '0;
  logic [3:0] ctl_o;
  logic [3:0] event_o;
  logic       wb_en_o;
  logic [7:0] wb_data_o;

  int checks = 0;
  int errors = 0;

  logic [3:0] exp_ctl = '0;
  logic [3:0] exp_evt = '0;
  logic       exp_wb  = 1'b0;
  logic [7:0] exp_wbd = '0;

  always #5 clk_i = ~clk_i;

  sysop_ctl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sysop_i(sysop_i), .sub_op_i(sub_op_i),
    .phase_i(phase_i), .irq_src_i(irq_src_i), .ctl_o(ctl_o), .event_o(event_o),
    .wb_en_o(wb_en_o), .wb_data_o(wb_data_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] next_ctl(logic [3:0] c, logic f, logic [3:0] s);
    logic [3:0] r = c;
    if (f && s[2:0] < 4) r[s[1:0]] = s[3];
    return r;
  endfunction

  function automatic logic [3:0] next_evt(logic [3:0] e, logic f, logic [3:0] s);
    logic [3:0] r = '0;
    if (f && s[3] && s[2:0] >= 4) r[s[1:0]] = 1'b1;
    return r & ~e;
  endfunction

  // one phase: drive at negedge, model the edge, check at next negedge
  task automatic step(logic op, logic [3:0] s, logic [1:0] ph, logic [3:0] src);
    logic f;
    string ctag;
    string etag;
    sysop_i = op; sub_op_i = s; phase_i = ph; irq_src_i = src;
    f = op && (ph == 2'd1);
    ctag = !f ? "R3" : (s[3] ? "R1" : "R2");
    etag = !f ? "R3" : (s[3] ? "R4" : "R5");
    @(posedge clk_i);
    exp_wb = f && (s == 4'b0100);
    if (exp_wb) exp_wbd = {src, exp_ctl};
    exp_ctl = next_ctl(exp_ctl, f, s);
    exp_evt = next_evt(exp_evt, f, s);
    @(negedge clk_i);
    check(ctag, {4'h0, ctl_o}, {4'h0, exp_ctl});
    check(etag, {4'h0, event_o}, {4'h0, exp_evt});
    check("R6", {7'h0, wb_en_o}, {7'h0, exp_wb});
    if (exp_wb) check("R6", wb_data_o, exp_wbd);
  endtask

  task automatic instr(logic op, logic [3:0] s, logic [3:0] src);
    for (int p = 0; p < 4; p++) begin
      step(op, s, 2'(p), src);
      if (p == 3) check("R8", {4'h0, event_o}, 8'h00);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R7", {ctl_o, event_o}, 8'h00);
    check("R7", {7'h0, wb_en_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7", {ctl_o, event_o}, 8'h00);

    // R1: set every persistent flag, then R2: clear two
    for (int i = 0; i < 4; i++) instr(1'b1, 4'(8 + i), 4'h0);
    check("R1", {4'h0, ctl_o}, 8'h0f);
    instr(1'b1, 4'h1, 4'h0);
    instr(1'b1, 4'h3, 4'h0);
    check("R2", {4'h0, ctl_o}, 8'h05);

    // R3: codes outside the update phase or without the strobe
    step(1'b1, 4'h8 + 4'h1, 2'd0, 4'h0);
    step(1'b1, 4'h0, 2'd2, 4'h0);
    step(1'b0, 4'hC, 2'd1, 4'h0);
    check("R3", {ctl_o, event_o}, 8'h50);

    // R4: every event bit, back to back
    for (int i = 4; i < 8; i++) instr(1'b1, 4'(8 + i), 4'h0);

    // R5: no-effect clear codes
    for (int i = 5; i < 8; i++) instr(1'b1, 4'(i), 4'h0);
    check("R5", {ctl_o, event_o}, 8'h50);

    // R6: status read right after a pulse, with a cause pattern
    instr(1'b1, 4'hD, 4'h0);
    instr(1'b1, 4'h4, 4'hA);
    check("R6", wb_data_o, 8'hA5);
    instr(1'b1, 4'h4, 4'h3);

    // random instruction streams, also random strobe per phase
    for (int n = 0; n < 600; n++) begin
      if (($urandom % 4) == 0) begin
        for (int p = 0; p < 4; p++)
          step(1'($urandom), 4'($urandom), 2'(p), 4'($urandom));
      end else begin
        instr(($urandom % 8) != 0, 4'($urandom), 4'($urandom));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule